// File: doc/BRIEF.md
# Subranging Frequency-to-Digital Converter

This block turns the square wave of a sensor-driven relaxation oscillator into a digital reading. A timer built on the system clock opens back-to-back gate windows of fixed length, each standing for one period of the slow reference tick. During each window the block counts rising edges of the input after bringing it into the clock domain through a short chain of flops. When a window closes, the count and the range code that was in force during that window are captured together as one 16-bit result, and a single-cycle strobe marks it.

The 3-bit range code works as a coarse exponent. A count above the upper limit moves the code up one step and a count below the lower limit moves it down one step. The limits are set so that a decade change in frequency after a step lands well inside the band again, which keeps the code from toggling when the input sits near a band edge. From the range code the block derives one-hot selects for the analog front end: a current-scaling path, a capacitor and a reference voltage. These selects keep the oscillator within one decade.

Top module: `subrange_fdc`

## Requirements
- R1: While reset is held and until the first strobe, the result word is 0 and the strobe is low. The range code is 2, so the current-path select is 3'b010, the capacitor select is 2'b01 and the voltage select is 3'b010.
- R2: Every GATE_CYCLES clock cycles the strobe is high for exactly one cycle. Bits 12..0 of the word then give the number of input rising edges in the window that just closed.
- R3: Bits 15..13 of the word give the range code that was in force during the window being reported, and not the updated code.
- R4: When a window count is greater than UP_LIMIT, the range code increases by one at the close of that window.
- R5: When a window count is less than DOWN_LIMIT, the range code decreases by one at the close of that window.
- R6: When a window count lies between DOWN_LIMIT and UP_LIMIT inclusive, the range code holds.
- R7: The range code stays within 0 to 5. An increase request at 5 and a decrease request at 0 leave it unchanged.
- R8: The selects follow the range code c and change at the same edge as the code. The current-path select is one-hot at bit c>>1. The capacitor select is one-hot at bit c[0]. The voltage select is one-hot at bit 2-(c>>1).
- R9: The edge count starts from zero in every window, so counts do not add up across windows.
- R10: A steady input level adds no counts. Only a low-to-high transition counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the gate timer counts these cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_in | input | 1 | Asynchronous oscillator pulse input |
| word_o | output | 16 | Range code in bits 15..13, edge count in bits 12..0 |
| word_valid_o | output | 1 | One-cycle strobe when word_o is updated |
| ipath_en_o | output | 3 | One-hot current-scaling path select |
| cap_en_o | output | 2 | One-hot capacitor select |
| vref_sel_o | output | 3 | One-hot reference-voltage select |

## Verification
The hardest conditions to reach are the two ends of the range code and the exact band limits. Saturation only shows up after several windows in a row have pushed the code the same way, and a limit test needs exactly UP_LIMIT or DOWN_LIMIT edges inside one window. The bench waits for each strobe and then sends an exact number of well-spaced pulses, all placed well before the window closes. A table of pulse counts walks the code up to 5, holds it there, walks it down to 0 and holds it there, and also places counts exactly on and just past each limit. Directed steps then hold the input high across windows and apply reset partway through a run.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

   localparam int SUB_W = 3;

   typedef logic [SUB_W-1:0] sub_t;

   typedef struct packed {
      logic [2:0] ipath;
      logic [1:0] cap;
      logic [2:0] vref;
   } fe_sel_t;

   // Range code to front-end selects; codes 6 and 7 never occur.
   function automatic fe_sel_t decode_sel(input sub_t code);
      fe_sel_t s;
      case (code[2:1])
         2'd0:    begin s.ipath = 3'b001; s.vref = 3'b100; end
         2'd1:    begin s.ipath = 3'b010; s.vref = 3'b010; end
         default: begin s.ipath = 3'b100; s.vref = 3'b001; end
      endcase
      s.cap = code[0] ? 2'b10 : 2'b01;
      return s;
   endfunction

endpackage

// File: rtl/fdc_edge_sync.sv
module fdc_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("fdc_edge_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] sync_q;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         last_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[STAGES-2:0], din};
         last_q <= sync_q[STAGES-1];
      end
   end

   assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/fdc_window_counter.sv
module fdc_window_counter #(
   parameter int CNT_W       = 13,
   parameter int GATE_CYCLES = 50000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise,
   output logic             win_end,
   output logic [CNT_W-1:0] win_cnt
);

   localparam int TMR_W = (GATE_CYCLES > 2) ? $clog2(GATE_CYCLES) : 1;
   localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(GATE_CYCLES - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   if (GATE_CYCLES < 2) begin : g_bad_gate
      $error("fdc_window_counter: GATE_CYCLES must be at least 2");
   end

   logic [TMR_W-1:0] tmr_q;
   logic [CNT_W-1:0] cnt_q;

   assign win_end = (tmr_q == TMR_LAST);
   // count including an edge arriving on the closing cycle, saturating
   assign win_cnt = (rise && cnt_q != CNT_MAX) ? cnt_q + 1'b1 : cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q <= '0;
         cnt_q <= '0;
      end else if (win_end) begin
         tmr_q <= '0;
         cnt_q <= '0;
      end else begin
         tmr_q <= tmr_q + 1'b1;
         cnt_q <= win_cnt;
      end
   end

endmodule

// File: rtl/fdc_range_ctrl.sv
module fdc_range_ctrl
   import fdc_pkg::*;
#(
   parameter int CNT_W      = 13,
   parameter int UP_LIMIT   = 5000,
   parameter int DOWN_LIMIT = 450,
   parameter int MAX_CODE   = 5,
   parameter int RESET_CODE = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_end,
   input  logic [CNT_W-1:0] win_cnt,
   output sub_t             sub_q,
   output fe_sel_t          sel_q
);

   localparam logic [CNT_W-1:0] UP_L   = CNT_W'(UP_LIMIT);
   localparam logic [CNT_W-1:0] DOWN_L = CNT_W'(DOWN_LIMIT);
   localparam sub_t             TOP_C  = SUB_W'(MAX_CODE);
   localparam sub_t             RST_C  = SUB_W'(RESET_CODE);

   if (DOWN_LIMIT >= UP_LIMIT || UP_LIMIT >= (1 << CNT_W)) begin : g_bad_limits
      $error("fdc_range_ctrl: need DOWN_LIMIT < UP_LIMIT < 2**CNT_W");
   end
   if (MAX_CODE >= (1 << SUB_W) || RESET_CODE > MAX_CODE) begin : g_bad_codes
      $error("fdc_range_ctrl: range codes out of field");
   end

   sub_t inc_c, dec_c, sub_d;
   logic over, under;

   // incrementer and decrementer side by side, each saturating
   assign inc_c = (sub_q == TOP_C) ? sub_q : sub_q + 1'b1;
   assign dec_c = (sub_q == '0)    ? sub_q : sub_q - 1'b1;
   assign over  = win_cnt > UP_L;
   assign under = win_cnt < DOWN_L;

   always_comb begin
      sub_d = sub_q;
      if (win_end) begin
         if (over)       sub_d = inc_c;
         else if (under) sub_d = dec_c;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sub_q <= RST_C;
         sel_q <= decode_sel(RST_C);
      end else begin
         sub_q <= sub_d;
         sel_q <= decode_sel(sub_d);
      end
   end

endmodule

// File: rtl/subrange_fdc.sv
module subrange_fdc
   import fdc_pkg::*;
#(
   parameter int CNT_W       = 13,
   parameter int GATE_CYCLES = 50000,
   parameter int UP_LIMIT    = 5000,
   parameter int DOWN_LIMIT  = 450,
   parameter int SYNC_STAGES = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   freq_in,
   output logic [SUB_W+CNT_W-1:0] word_o,
   output logic                   word_valid_o,
   output logic [2:0]             ipath_en_o,
   output logic [1:0]             cap_en_o,
   output logic [2:0]             vref_sel_o
);

   localparam int MAX_CODE   = 5;
   localparam int RESET_CODE = 2;

   logic             rise, win_end;
   logic [CNT_W-1:0] win_cnt;
   sub_t             sub_q;
   fe_sel_t          sel_q;

   fdc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  (freq_in),
      .rise (rise)
   );

   fdc_window_counter #(.CNT_W(CNT_W), .GATE_CYCLES(GATE_CYCLES)) u_win (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise   (rise),
      .win_end(win_end),
      .win_cnt(win_cnt)
   );

   fdc_range_ctrl #(
      .CNT_W     (CNT_W),
      .UP_LIMIT  (UP_LIMIT),
      .DOWN_LIMIT(DOWN_LIMIT),
      .MAX_CODE  (MAX_CODE),
      .RESET_CODE(RESET_CODE)
   ) u_rng (
      .clk    (clk),
      .rst_n  (rst_n),
      .win_end(win_end),
      .win_cnt(win_cnt),
      .sub_q  (sub_q),
      .sel_q  (sel_q)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_o       <= '0;
         word_valid_o <= 1'b0;
      end else begin
         word_valid_o <= win_end;
         if (win_end) word_o <= {sub_q, win_cnt};
      end
   end

   assign ipath_en_o = sel_q.ipath;
   assign cap_en_o   = sel_q.cap;
   assign vref_sel_o = sel_q.vref;

endmodule

// File: rtl/fdc_chk.sv
module fdc_chk #(
   parameter int CNT_W      = 13,
   parameter int UP_LIMIT   = 5000,
   parameter int DOWN_LIMIT = 450
) (
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W+2:0] word_o,
   input logic             word_valid_o,
   input logic [2:0]       sub_q,
   input logic [2:0]       ipath_en_o,
   input logic [1:0]       cap_en_o,
   input logic [2:0]       vref_sel_o
);

   logic [2:0]       w_code;
   logic [CNT_W-1:0] w_cnt;
   assign w_code = word_o[CNT_W+2:CNT_W];
   assign w_cnt  = word_o[CNT_W-1:0];

   // R2
   strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |=> !word_valid_o);

   // R3
   word_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      word_valid_o |-> w_code == $past(sub_q));

   // R3
   code_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !word_valid_o |-> $stable(sub_q));

   // R4
   step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && w_cnt > CNT_W'(UP_LIMIT) && w_code < 3'd5) |-> sub_q == w_code + 3'd1);

   // R5
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && w_cnt < CNT_W'(DOWN_LIMIT) && w_code > 3'd0) |-> sub_q == w_code - 3'd1);

   // R6
   hold_band_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (word_valid_o && w_cnt >= CNT_W'(DOWN_LIMIT) && w_cnt <= CNT_W'(UP_LIMIT)) |-> sub_q == w_code);

   // R7
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_q <= 3'd5);

   // R8
   sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ipath_en_o) == 1 && $countones(cap_en_o) == 1 && $countones(vref_sel_o) == 1);

endmodule

bind subrange_fdc fdc_chk #(
   .CNT_W     (CNT_W),
   .UP_LIMIT  (UP_LIMIT),
   .DOWN_LIMIT(DOWN_LIMIT)
) u_fdc_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .word_o      (word_o),
   .word_valid_o(word_valid_o),
   .sub_q       (sub_q),
   .ipath_en_o  (ipath_en_o),
   .cap_en_o    (cap_en_o),
   .vref_sel_o  (vref_sel_o)
);

// File: tb/tb_subrange_fdc.sv
module tb_subrange_fdc;

   localparam int GATE = 512;
   localparam int UPL  = 60;
   localparam int DNL  = 15;
   localparam int NVEC = 18;

   // {pulses[7:0], code during window[2:0], code after window[2:0]}
   localparam logic [13:0] VEC [0:NVEC-1] = '{
      {8'd30, 3'd1, 3'd1}, {8'd61, 3'd1, 3'd2}, {8'd60, 3'd2, 3'd2},
      {8'd15, 3'd2, 3'd2}, {8'd14, 3'd2, 3'd1}, {8'd80, 3'd1, 3'd2},
      {8'd80, 3'd2, 3'd3}, {8'd90, 3'd3, 3'd4}, {8'd99, 3'd4, 3'd5},
      {8'd99, 3'd5, 3'd5}, {8'd40, 3'd5, 3'd5}, {8'd0,  3'd5, 3'd4},
      {8'd5,  3'd4, 3'd3}, {8'd1,  3'd3, 3'd2}, {8'd2,  3'd2, 3'd1},
      {8'd0,  3'd1, 3'd0}, {8'd0,  3'd0, 3'd0}, {8'd16, 3'd0, 3'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freq_in = 1'b0;
   logic [15:0] word_o;
   logic        word_valid_o;
   logic [2:0]  ipath_en_o;
   logic [1:0]  cap_en_o;
   logic [2:0]  vref_sel_o;

   int checks = 0;
   int errors = 0;
   bit period_on = 1'b0;

   always #10 clk = ~clk;

   subrange_fdc #(
      .CNT_W      (13),
      .GATE_CYCLES(GATE),
      .UP_LIMIT   (UPL),
      .DOWN_LIMIT (DNL),
      .SYNC_STAGES(2)
   ) dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .freq_in     (freq_in),
      .word_o      (word_o),
      .word_valid_o(word_valid_o),
      .ipath_en_o  (ipath_en_o),
      .cap_en_o    (cap_en_o),
      .vref_sel_o  (vref_sel_o)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] exp_sel(input logic [2:0] c);
      logic [2:0] ip, vr;
      logic [1:0] cp;
      ip = 3'b001 << (c >> 1);
      vr = 3'b001 << (3'd2 - (c >> 1));
      cp = 2'b01 << c[0];
      return {ip, cp, vr};
   endfunction

   task automatic check_sel(input logic [2:0] c, input string req);
      check({ipath_en_o, cap_en_o, vref_sel_o} == exp_sel(c), req,
            {ipath_en_o, cap_en_o, vref_sel_o}, exp_sel(c));
   endtask

   task automatic send_pulses(input int n);
      for (int i = 0; i < n; i++) begin
         freq_in = 1'b1;
         repeat (2) @(negedge clk);
         freq_in = 1'b0;
         repeat (2) @(negedge clk);
      end
   endtask

   task automatic wait_valid();
      int k = 0;
      while (!word_valid_o && k < 3 * GATE) begin
         @(negedge clk);
         k++;
      end
      if (!word_valid_o) check(1'b0, "R2 strobe missing", 0, 1);
   endtask

   // R2: strobe spacing
   initial begin
      int gap = 0;
      bit seen = 1'b0;
      forever begin
         @(negedge clk);
         gap++;
         if (period_on && word_valid_o) begin
            if (seen) check(gap == GATE, "R2 period", gap, GATE);
            seen = 1'b1;
            gap = 0;
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [7:0] n;
      logic [2:0] cin, cout;
      repeat (4) @(negedge clk);
      // R1 reset state
      check(word_o == 16'h0, "R1 word", word_o, 0);
      check(word_valid_o == 1'b0, "R1 strobe", word_valid_o, 0);
      check_sel(3'd2, "R1 selects");
      rst_n = 1'b1;
      period_on = 1'b1;
      repeat (20) @(negedge clk);
      check(word_o == 16'h0 && !word_valid_o, "R1 before first window", word_o, 0);
      check_sel(3'd2, "R1 selects before first window");

      // first window, no pulses: code 2 reported, then steps down (R5)
      wait_valid();
      check(word_o == {3'd2, 13'd0}, "R3 first word", word_o, {3'd2, 13'd0});
      check_sel(3'd1, "R5 first step down");
      @(negedge clk);
      check(!word_valid_o, "R2 strobe one cycle", word_valid_o, 0);

      for (int v = 0; v < NVEC; v++) begin
         {n, cin, cout} = VEC[v];
         send_pulses(int'(n));
         wait_valid();
         // R2 count, R3 code, R9 fresh count each window
         check(word_o[12:0] == 13'(n), "R2 R9 count", word_o[12:0], n);
         check(word_o[15:13] == cin, "R3 reported code", word_o[15:13], cin);
         // R4 R5 R6 R7 via updated selects, decoded per R8
         check_sel(cout, "R4 R5 R6 R7 R8 code update");
         @(negedge clk);
         check(!word_valid_o, "R2 strobe one cycle", word_valid_o, 0);
      end

      // R10: input rises once, then stays high through a whole window
      freq_in = 1'b1;
      wait_valid();
      check(word_o == {3'd0, 13'd1}, "R10 single rise", word_o, {3'd0, 13'd1});
      @(negedge clk);
      wait_valid();
      check(word_o == {3'd0, 13'd0}, "R10 steady high", word_o, 0);
      check_sel(3'd0, "R7 floor held");
      freq_in = 1'b0;

      // R1 reset mid-run
      period_on = 1'b0;
      repeat (37) @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check(word_o == 16'h0 && !word_valid_o, "R1 reset mid-run", word_o, 0);
      check_sel(3'd2, "R1 selects mid-run reset");

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule